// File: doc/BRIEF.md
# Bit-Serial Frame Check Sequence Unit

This block computes a 16-bit cyclic redundancy check one bit at a time. A synchronous serial transmitter and receiver share it. A start-of-frame strobe loads the register with a preset value. Each cycle that carries a valid bit then advances the register by that bit. The preset value is all ones or all zeros, and it is taken from a small configuration register. Two generator polynomials are available: CRC-CCITT and CRC-16.

On transmit, a send strobe moves the unit from accumulating to emitting. The register is then shifted out most significant bit first, one bit per valid cycle, for sixteen cycles. A done pulse follows the last bit. When the bit-oriented framing mode is on, the emitted bits are inverted.

On receive, the incoming frame is fed through the register together with its trailing check field. The result is reported as a pass/fail flag. Outside the bit-oriented mode the remainder must be zero. Inside it, the remainder must equal a fixed nonzero constant. While the link runs in asynchronous character mode the unit is unused and holds its state.

Top module: `serial_crc_unit`

## Requirements
- R1: When `frameStart` is high and `asyncMode` is low, the register is loaded on that edge: all ones if the preset register holds 1, all zeros if it holds 0.
- R2: The preset register takes `cfgPresetOnes` on an edge where `cfgLoad` is high. It is cleared to 0 by `rstN` low and by `chanReset` high.
- R3: Each cycle with `bitValid` high, with no frame start and no shift-out active, advances the register one bit, most significant bit first. The feedback is crc[15] xor `dataBit`. `polySel`=0 selects 0x1021 (x^16+x^12+x^5+1) and `polySel`=1 selects 0x8005 (x^16+x^15+x^2+1). A cycle with `bitValid` low leaves the register unchanged.
- R4: A `sendCrc` pulse while idle raises `txActive` on the next edge. Then, on each cycle with `bitValid` high, `txBit` presents the current register MSB, starting at bit 15, and the register shifts left. Cycles with `bitValid` low hold the output bit.
- R5: With `sdlcMode`=1, every shifted-out `txBit` is the inverse of the register MSB. With `sdlcMode`=0 it is not inverted.
- R6: After the 16th shifted bit, `txDone` is high for exactly one cycle, `txActive` is low, and `crcValue` is zero.
- R7: `rxCrcOk` is 1 when `sdlcMode`=0 and the register is 0x0000, or when `sdlcMode`=1 and the register is 0x1D0F. Otherwise it is 0.
- R8: While `asyncMode` is high, `frameStart`, `bitValid` and `sendCrc` have no effect: `crcValue` holds and no shift-out starts.
- R9: After reset, `crcValue` is 0, `txActive`, `txDone` and `txBit` are 0, and the preset register is 0.
- R10: A `frameStart` during shift-out aborts it. `txActive` drops, no `txDone` pulse is produced, and the preset is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanReset | input | 1 | Channel reset, clears preset register and shift-out |
| cfgLoad | input | 1 | Write strobe for the preset register |
| cfgPresetOnes | input | 1 | Preset value to write (1 = all ones) |
| polySel | input | 1 | 0 = CRC-CCITT, 1 = CRC-16 |
| sdlcMode | input | 1 | Bit-oriented framing: invert on send, residue check on receive |
| asyncMode | input | 1 | Asynchronous mode, unit frozen |
| frameStart | input | 1 | Reload preset |
| bitValid | input | 1 | One serial bit this cycle |
| dataBit | input | 1 | Serial data bit |
| sendCrc | input | 1 | Begin shifting the check field out |
| crcValue | output | 16 | Current register contents |
| txBit | output | 1 | Outgoing check bit during shift-out, else 0 |
| txActive | output | 1 | Shift-out in progress |
| txDone | output | 1 | One-cycle pulse after the last check bit |
| rxCrcOk | output | 1 | Receive remainder matches the expected residue |

## Verification
The hardest state to reach is the bit-oriented receive pass. It needs a frame whose inverted check field was produced by this same unit and then fed back bit for bit, with idle gaps inside both the data and the shift-out. The stimulus gets there by looping each randomly built transmit frame straight into a receive frame, using every emitted bit. Some frames have one bit flipped on the way, so the flag must also be seen to fail. An abort in the middle of shift-out and activity during asynchronous mode are reached by directed sequences.

// File: rtl/serial_crc_pkg.sv
package serial_crc_pkg;
  typedef struct packed {
    logic load;
    logic advance;
    logic shift;
  } crc_strobe_t;
endpackage

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import serial_crc_pkg::*;
#(
  parameter int CRC_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        chanReset,
  input  logic        cfgLoad,
  input  logic        cfgPresetOnes,
  input  logic        asyncMode,
  input  logic        frameStart,
  input  logic        bitValid,
  input  logic        sendCrc,
  output crc_strobe_t strobe,
  output logic        presetSel,
  output logic        txActive,
  output logic        txDone
);
  localparam int CNT_W = $clog2(CRC_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CRC_W - 1);

  logic live;
  logic [CNT_W-1:0] bitCnt;

  assign live = !asyncMode;

  always_comb begin
    strobe.load    = live && frameStart;
    strobe.shift   = live && !frameStart && txActive && bitValid;
    strobe.advance = live && !frameStart && !txActive && bitValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN || chanReset) presetSel <= 1'b0;
    else if (cfgLoad)       presetSel <= cfgPresetOnes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txActive <= 1'b0;
      txDone   <= 1'b0;
      bitCnt   <= '0;
    end else begin
      txDone <= 1'b0;
      if (chanReset || strobe.load) begin
        txActive <= 1'b0;
        bitCnt   <= '0;
      end else if (strobe.shift) begin
        if (bitCnt == LAST_BIT) begin
          txActive <= 1'b0;
          txDone   <= 1'b1;
          bitCnt   <= '0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end else if (live && sendCrc && !txActive) begin
        txActive <= 1'b1;
        bitCnt   <= '0;
      end
    end
  end
endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
  import serial_crc_pkg::*;
#(
  parameter int               CRC_W   = 16,
  parameter logic [CRC_W-1:0] POLY_A  = 16'h1021,
  parameter logic [CRC_W-1:0] POLY_B  = 16'h8005,
  parameter logic [CRC_W-1:0] RESIDUE = 16'h1D0F
) (
  input  logic             clk,
  input  logic             rstN,
  input  crc_strobe_t      strobe,
  input  logic             presetSel,
  input  logic             polySel,
  input  logic             sdlcMode,
  input  logic             txActive,
  input  logic             dataBit,
  output logic [CRC_W-1:0] crcReg,
  output logic             txBit,
  output logic             rxCrcOk
);
  logic [CRC_W-1:0] poly;
  logic             feedback;
  logic [CRC_W-1:0] stepped;

  assign poly     = polySel ? POLY_B : POLY_A;
  assign feedback = crcReg[CRC_W-1] ^ dataBit;
  assign stepped  = {crcReg[CRC_W-2:0], 1'b0} ^ (feedback ? poly : '0);

  always_ff @(posedge clk) begin
    if (!rstN)               crcReg <= '0;
    else if (strobe.load)    crcReg <= {CRC_W{presetSel}};
    else if (strobe.shift)   crcReg <= {crcReg[CRC_W-2:0], 1'b0};
    else if (strobe.advance) crcReg <= stepped;
  end

  assign txBit   = txActive && (crcReg[CRC_W-1] ^ sdlcMode);
  assign rxCrcOk = sdlcMode ? (crcReg == RESIDUE) : (crcReg == '0);
endmodule

// File: rtl/serial_crc_unit.sv
module serial_crc_unit
  import serial_crc_pkg::*;
#(
  parameter int               CRC_W   = 16,
  parameter logic [CRC_W-1:0] POLY_A  = 16'h1021,
  parameter logic [CRC_W-1:0] POLY_B  = 16'h8005,
  parameter logic [CRC_W-1:0] RESIDUE = 16'h1D0F
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanReset,
  input  logic             cfgLoad,
  input  logic             cfgPresetOnes,
  input  logic             polySel,
  input  logic             sdlcMode,
  input  logic             asyncMode,
  input  logic             frameStart,
  input  logic             bitValid,
  input  logic             dataBit,
  input  logic             sendCrc,
  output logic [CRC_W-1:0] crcValue,
  output logic             txBit,
  output logic             txActive,
  output logic             txDone,
  output logic             rxCrcOk
);
  crc_strobe_t strobe;
  logic        presetSel;

  crc_ctrl #(.CRC_W(CRC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .chanReset(chanReset), .cfgLoad(cfgLoad),
    .cfgPresetOnes(cfgPresetOnes), .asyncMode(asyncMode),
    .frameStart(frameStart), .bitValid(bitValid), .sendCrc(sendCrc),
    .strobe(strobe), .presetSel(presetSel), .txActive(txActive),
    .txDone(txDone)
  );

  crc_datapath #(
    .CRC_W(CRC_W), .POLY_A(POLY_A), .POLY_B(POLY_B), .RESIDUE(RESIDUE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .presetSel(presetSel),
    .polySel(polySel), .sdlcMode(sdlcMode), .txActive(txActive),
    .dataBit(dataBit), .crcReg(crcValue), .txBit(txBit), .rxCrcOk(rxCrcOk)
  );
endmodule

// File: rtl/serial_crc_unit_chk.sv
module serial_crc_unit_chk #(
  parameter int CRC_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             chanReset,
  input logic             frameStart,
  input logic             asyncMode,
  input logic [CRC_W-1:0] crcValue,
  input logic             txActive,
  input logic             txDone,
  input logic             presetSel
);
  AST_LOAD_PRESET: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !asyncMode) |=> crcValue == {CRC_W{$past(presetSel)}}); // R1

  AST_CHAN_CLEARS_PRESET: assert property (@(posedge clk) disable iff (!rstN)
    chanReset |=> !presetSel); // R2

  AST_DONE_ENDS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> $fell(txActive)); // R6

  AST_DONE_EMPTY_REG: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> crcValue == '0); // R6

  AST_ASYNC_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    asyncMode |=> $stable(crcValue)); // R8

  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (txActive && frameStart && !asyncMode) |=> !txDone && !txActive); // R10
endmodule

bind serial_crc_unit serial_crc_unit_chk #(.CRC_W(CRC_W)) u_chk (.*);

// File: tb/serial_crc_unit_bench.sv
module serial_crc_unit_bench;
  logic clk = 1'b0;
  logic rstN, chanReset, cfgLoad, cfgPresetOnes, polySel, sdlcMode;
  logic asyncMode, frameStart, bitValid, dataBit, sendCrc;
  logic [15:0] crcValue;
  logic txBit, txActive, txDone, rxCrcOk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  serial_crc_unit u_serial_crc_unit (.*);

  function automatic logic [15:0] stepCrc(logic [15:0] c, logic b, logic p);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? (p ? 16'h8005 : 16'h1021) : 16'h0000);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    frameStart = 0; bitValid = 0; sendCrc = 0; cfgLoad = 0; chanReset = 0;
  endtask

  task automatic setPreset(logic v);
    cfgLoad = 1; cfgPresetOnes = v; tick();
  endtask

  task automatic maybeGap();
    if ($urandom_range(0, 3) == 0) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] bits;
    logic [15:0] model;
    logic [15:0] sent;
    logic [15:0] held;
    void'($urandom(32'd20240607));
    rstN = 0; chanReset = 0; cfgLoad = 0; cfgPresetOnes = 0; polySel = 0;
    sdlcMode = 0; asyncMode = 0; frameStart = 0; bitValid = 0; dataBit = 0;
    sendCrc = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    check("R9 crcValue", crcValue, 0);
    check("R9 txActive", txActive, 0);
    check("R9 txDone", txDone, 0);
    check("R9 txBit", txBit, 0);
    frameStart = 1; tick();
    check("R9 R1 preset after reset", crcValue, 16'h0000);
    setPreset(1);
    frameStart = 1; tick();
    check("R1 preset ones", crcValue, 16'hFFFF);
    setPreset(0);
    frameStart = 1; tick();
    check("R2 R1 preset zeros", crcValue, 16'h0000);

    for (int n = 0; n < 60; n++) begin
      int len;
      logic p, s, pre, corrupt;
      int flip;
      p = 1'($urandom_range(0, 1)); s = 1'($urandom_range(0, 1));
      pre = 1'($urandom_range(0, 1));
      if (n < 4) begin p = n[0]; s = n[1]; end
      corrupt = (n >= 8) && ($urandom_range(0, 3) == 0);
      len = $urandom_range(1, 112);
      bits = {$urandom, $urandom, $urandom, $urandom};
      polySel = p; sdlcMode = s;
      setPreset(pre);
      frameStart = 1; tick();
      model = {16{pre}};
      for (int i = 0; i < len; i++) begin
        maybeGap();
        bitValid = 1; dataBit = bits[i]; tick();
        model = stepCrc(model, bits[i], p);
      end
      check("R3 data remainder", crcValue, model);
      sendCrc = 1; tick();
      check("R4 txActive raised", txActive, 1);
      for (int i = 0; i < 16; i++) begin
        maybeGap();
        check("R4 R5 tx bit", txBit, model[15 - i] ^ s);
        sent[15 - i] = txBit;
        bitValid = 1; tick();
      end
      check("R6 done pulse", txDone, 1);
      check("R6 inactive", txActive, 0);
      check("R6 register empty", crcValue, 0);
      tick();
      check("R6 done one cycle", txDone, 0);
      flip = corrupt ? $urandom_range(0, len + 15) : -1;
      frameStart = 1; tick();
      model = {16{pre}};
      for (int i = 0; i < len + 16; i++) begin
        logic b;
        b = (i < len) ? bits[i] : sent[len + 15 - i];
        if (i == flip) b = ~b;
        maybeGap();
        bitValid = 1; dataBit = b; tick();
        model = stepCrc(model, b, p);
      end
      check("R7 rx remainder", crcValue, model);
      check("R7 rxCrcOk", rxCrcOk, s ? (model == 16'h1D0F) : (model == 0));
      if (!p && !corrupt) check("R7 clean frame passes", rxCrcOk, 1);
      if (corrupt && !s) check("R7 corrupted frame fails", rxCrcOk, 0);
    end

    polySel = 0; sdlcMode = 0;
    setPreset(1);
    frameStart = 1; tick();
    bitValid = 1; dataBit = 1; tick();
    held = crcValue;
    asyncMode = 1;
    frameStart = 1; tick();
    check("R8 frameStart ignored", crcValue, held);
    bitValid = 1; dataBit = 0; tick();
    check("R8 bitValid ignored", crcValue, held);
    sendCrc = 1; tick();
    check("R8 sendCrc ignored", txActive, 0);
    asyncMode = 0;

    chanReset = 1; tick();
    frameStart = 1; tick();
    check("R2 chanReset clears preset", crcValue, 16'h0000);

    setPreset(1);
    frameStart = 1; tick();
    bitValid = 1; dataBit = 0; tick();
    sendCrc = 1; tick();
    repeat (3) begin bitValid = 1; tick(); end
    check("R10 active before abort", txActive, 1);
    frameStart = 1; tick();
    check("R10 aborted", txActive, 0);
    check("R10 no done", txDone, 0);
    check("R10 preset loaded", crcValue, 16'hFFFF);
    tick();
    check("R10 no late done", txDone, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule